// File: doc/BRIEF.md
# Transmit Collision Count Status Encoder

This block follows the collisions that occur while one frame is being sent. From them it builds the 4-bit collision field and the excessive-collision flag that go into the transmit completion status. A transmit controller pulses `pkt_start` when a frame begins and `coll_strobe` once for each collided attempt. It pulses `pkt_end` when the frame leaves the wire. The block also raises a one-cycle `tx_abort` when the collision limit is reached, so the retry logic stops retransmitting.

Two encodings are supported, and the mode is taken from `retry_ext` at start of packet.

- **Plain mode** reports the raw collision count and aborts on the 16th collision.
- **Extended-retry mode** groups collisions into blocks of 16. One excessive event is counted per completed block. The field packs the number of completed blocks together with single and multiple flags for the collisions left over. The abort comes after the fourth completed block, which is the 64th collision.

A four-state controller sequences the block.

- **IDLE** is the state after reset.
- **SEND** is the state while a frame is in flight.
- **ABORT** lasts one cycle after the limit is reached.
- **HOLD** keeps the status frozen.

The transitions are:

- start: any state goes to SEND on `pkt_start`.
- finish: SEND goes to HOLD on `pkt_end`.
- limit: SEND goes to ABORT on the limit collision.
- settle: ABORT goes to HOLD on its own.

Top module: `txcoll_status_enc`

## Requirements
- R1: While reset is held and after it is released, `coll_field` is 0, `exc_coll` is 0 and `tx_abort` is 0.
- R2: In plain mode (`retry_ext`=0 at start), `coll_field` equals the number of collisions counted for the current frame. It reads it one cycle after each strobe.
- R3: In plain mode, the 16th collision sets `exc_coll` to 1, wraps `coll_field` to 0 and pulses `tx_abort` high for exactly one cycle.
- R4: In extended mode (`retry_ext`=1 at start), with n collisions counted, the field is set as follows:
  - `coll_field[3:2]` = floor(n/16) mod 4.
  - `coll_field[1]` = 1 when n mod 16 is 2 or more.
  - `coll_field[0]` = 1 when n mod 16 equals 1.
  - For example, 33 collisions give 4'b1001.
- R5: In extended mode, the 64th collision sets `exc_coll` to 1, gives `coll_field` = 0 and pulses `tx_abort` for exactly one cycle. No earlier collision sets `exc_coll`.
- R6: `pkt_start` clears the count and `exc_coll` in the next cycle and latches the mode. A change of `retry_ext` after start has no effect on the frame in progress.
- R7: After `pkt_end` or an abort, and before any start, `coll_field` and `exc_coll` stay unchanged. Further collisions and end strobes are ignored, and so are any that arrive after reset and before the first start.
- R8: A collision in the same cycle as `pkt_end` is counted.
- R9: `pkt_start` takes priority over a collision or end in the same cycle. The frame restarts with a count of 0 and that collision is not counted, even in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Start-of-frame strobe |
| coll_strobe | input | 1 | One pulse per collided attempt |
| pkt_end | input | 1 | End-of-frame strobe |
| retry_ext | input | 1 | Extended-retry encoding select, sampled at start |
| coll_field | output | 4 | Collision status field |
| exc_coll | output | 1 | Excessive-collision status flag |
| tx_abort | output | 1 | One-cycle abort indication at the collision limit |

## Verification
The frames carry collision counts chosen to land on the boundaries of both encodings: 0, 1, 2, 5, 15, 16, 18, 33 and 64. A count of 1 against 2 separates the single flag from the multiple flag. A count of 16 separates the plain-mode abort from the first extended block, and 33 checks block packing together with the leftover flag. One frame flips `retry_ext` after start, where plain and extended output differ (3 against 4'b0010). Further frames place strobes in the same cycle as start or end, and send strobes after an end or abort, which tells a counter that still runs apart from one that is frozen.

// File: rtl/txcoll_pkg.sv
package txcoll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_ABORT = 2'd2,
        ST_HOLD  = 2'd3
    } txc_state_e;
endpackage

// File: rtl/txcoll_counter.sv
module txcoll_counter #(
    parameter int ATTEMPTS    = 16,
    parameter int EVENT_LIMIT = 4,
    localparam int RES_W = $clog2(ATTEMPTS),
    localparam int EV_W  = $clog2(EVENT_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [RES_W-1:0] residual,
    output logic [EV_W-1:0]  events
);
    localparam logic [RES_W-1:0] RES_TOP = RES_W'(ATTEMPTS - 1);
    localparam logic [EV_W-1:0]  EV_TOP  = EV_W'(EVENT_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            residual <= '0;
            events   <= '0;
        end else if (inc) begin
            if (residual == RES_TOP) begin
                residual <= '0;
                if (events != EV_TOP) begin
                    events <= events + 1'b1;
                end
            end else begin
                residual <= residual + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txcoll_field_enc.sv
module txcoll_field_enc #(
    parameter int ATTEMPTS    = 16,
    parameter int EVENT_LIMIT = 4,
    localparam int RES_W = $clog2(ATTEMPTS),
    localparam int EV_W  = $clog2(EVENT_LIMIT + 1),
    localparam int GRP_W = RES_W - 2
) (
    input  logic             ext_mode,
    input  logic [RES_W-1:0] residual,
    input  logic [EV_W-1:0]  events,
    output logic [RES_W-1:0] field
);
    logic [GRP_W-1:0] grp;
    logic             multi;
    logic             single;

    generate
        if (EV_W >= GRP_W) begin : g_ev_trunc
            assign grp = events[GRP_W-1:0];
        end else begin : g_ev_pad
            assign grp = GRP_W'(events);
        end
    endgenerate

    always_comb begin
        multi  = (residual > RES_W'(1));
        single = (residual == RES_W'(1));
        if (ext_mode) begin
            field = {grp, multi, single};
        end else begin
            field = residual;
        end
    end
endmodule

// File: rtl/txcoll_status_enc.sv
module txcoll_status_enc #(
    parameter int ATTEMPTS    = 16,
    parameter int EVENT_LIMIT = 4,
    localparam int RES_W = $clog2(ATTEMPTS),
    localparam int EV_W  = $clog2(EVENT_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             coll_strobe,
    input  logic             pkt_end,
    input  logic             retry_ext,
    output logic [RES_W-1:0] coll_field,
    output logic             exc_coll,
    output logic             tx_abort
);
    import txcoll_pkg::*;

    localparam logic [RES_W-1:0] RES_TOP = RES_W'(ATTEMPTS - 1);
    localparam logic [EV_W-1:0]  EV_LAST = EV_W'(EVENT_LIMIT - 1);

    txc_state_e       st_q;
    txc_state_e       st_d;
    logic             mode_q;
    logic             exc_q;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             exc_set;
    logic             limit_hit;
    logic [RES_W-1:0] residual;
    logic [EV_W-1:0]  events;

    txcoll_counter #(
        .ATTEMPTS    (ATTEMPTS),
        .EVENT_LIMIT (EVENT_LIMIT)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .residual (residual),
        .events   (events)
    );

    txcoll_field_enc #(
        .ATTEMPTS    (ATTEMPTS),
        .EVENT_LIMIT (EVENT_LIMIT)
    ) u_enc (
        .ext_mode (mode_q),
        .residual (residual),
        .events   (events),
        .field    (coll_field)
    );

    assign limit_hit = (residual == RES_TOP) && (!mode_q || (events == EV_LAST));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions and control outputs
    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        exc_set = 1'b0;
        if (pkt_start) begin
            st_d    = ST_SEND;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_SEND: begin
                    if (coll_strobe) begin
                        cnt_inc = 1'b1;
                        if (limit_hit) begin
                            exc_set = 1'b1;
                            st_d    = ST_ABORT;
                        end else if (pkt_end) begin
                            st_d = ST_HOLD;
                        end
                    end else if (pkt_end) begin
                        st_d = ST_HOLD;
                    end
                end
                ST_ABORT: begin
                    st_d = ST_HOLD;
                end
                ST_HOLD: begin
                    st_d = ST_HOLD;
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // frame-scoped mode and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            exc_q  <= 1'b0;
        end else if (pkt_start) begin
            mode_q <= retry_ext;
            exc_q  <= 1'b0;
        end else if (exc_set) begin
            exc_q <= 1'b1;
        end
    end

    assign exc_coll = exc_q;
    assign tx_abort = (st_q == ST_ABORT);
endmodule

// File: rtl/txcoll_status_chk.sv
module txcoll_status_chk (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pkt_start,
    input logic                   coll_strobe,
    input logic [3:0]             coll_field,
    input logic                   exc_coll,
    input logic                   tx_abort,
    input logic                   mode_q,
    input txcoll_pkg::txc_state_e st_q
);
    import txcoll_pkg::*;

    // R3
    abort_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    // R5
    abort_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> exc_coll);

    // R5
    flag_rise_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_coll) |-> tx_abort);

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> (coll_field == 4'd0 && !exc_coll && !tx_abort));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !pkt_start) |=> ($stable(coll_field) && $stable(exc_coll)));

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && !mode_q && coll_strobe && !pkt_start && coll_field != 4'd15)
        |=> (coll_field == $past(coll_field) + 4'd1));
endmodule

bind txcoll_status_enc txcoll_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_start   (pkt_start),
    .coll_strobe (coll_strobe),
    .coll_field  (coll_field),
    .exc_coll    (exc_coll),
    .tx_abort    (tx_abort),
    .mode_q      (mode_q),
    .st_q        (st_q)
);

// File: tb/sim_txcoll_status_enc.sv
`timescale 1ns/1ps
module sim_txcoll_status_enc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0;
    logic       coll_strobe = 1'b0;
    logic       pkt_end = 1'b0;
    logic       retry_ext = 1'b0;
    logic [3:0] coll_field;
    logic       exc_coll;
    logic       tx_abort;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_total = 0;
    bit m_mode = 0;
    bit m_exc = 0;
    bit m_abort = 0;
    bit m_active = 0;

    always #10 clk = ~clk;

    txcoll_status_enc u0 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .coll_strobe(coll_strobe),
        .pkt_end(pkt_end), .retry_ext(retry_ext),
        .coll_field(coll_field), .exc_coll(exc_coll), .tx_abort(tx_abort)
    );

    function automatic logic [3:0] exp_field();
        int r;
        r = m_total % 16;
        if (m_mode) return {2'((m_total / 16) % 4), (r >= 2), (r == 1)};
        return 4'(r);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "coll_field", int'(coll_field), int'(exp_field()));
        check(tag, "exc_coll", int'(exc_coll), int'(m_exc));
        check(tag, "tx_abort", int'(tx_abort), int'(m_abort));
    endtask

    task automatic model_step();
        m_abort = 0;
        if (!rst_n) begin
            m_total = 0; m_mode = 0; m_exc = 0; m_active = 0;
        end else if (pkt_start) begin
            m_total = 0; m_mode = retry_ext; m_exc = 0; m_active = 1;
        end else if (m_active) begin
            if (coll_strobe) begin
                m_total++;
                if (m_total == (m_mode ? 64 : 16)) begin
                    m_exc = 1; m_abort = 1; m_active = 0;
                end else if (pkt_end) m_active = 0;
            end else if (pkt_end) m_active = 0;
        end
    endtask

    task automatic cyc(string tag, bit ps, bit co, bit pe, bit rx);
        pkt_start = ps; coll_strobe = co; pkt_end = pe; retry_ext = rx;
        @(posedge clk);
        model_step();
        @(negedge clk);
        pkt_start = 0; coll_strobe = 0; pkt_end = 0;
        compare(tag);
    endtask

    task automatic colls(string tag, int n, bit rx);
        for (int i = 0; i < n; i++) begin
            cyc(tag, 0, 1, 0, rx);
            if (i % 3 == 2) cyc(tag, 0, 0, 0, rx);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        compare("R1");
        cyc("R1", 0, 1, 0, 0);
        rst_n = 1;
        cyc("R1", 0, 0, 0, 0);
        // R7: strobes before any start ignored
        cyc("R7", 0, 1, 0, 0);
        cyc("R7", 0, 1, 1, 1);
        // R2: plain count of 5
        cyc("R2", 1, 0, 0, 0);
        colls("R2", 5, 0);
        cyc("R2", 0, 0, 1, 0);
        // R7: hold after end
        colls("R7", 4, 0);
        cyc("R7", 0, 0, 1, 0);
        // R3: plain abort at 16, then ignored strobes
        cyc("R3", 1, 0, 0, 0);
        colls("R3", 15, 0);
        cyc("R3", 0, 1, 0, 0);
        cyc("R3", 0, 0, 0, 0);
        colls("R7", 3, 0);
        cyc("R7", 0, 0, 1, 0);
        // R4: extended 1, 2, 18, 33
        cyc("R4", 1, 0, 0, 1);
        cyc("R4", 0, 1, 0, 1);
        cyc("R4", 0, 1, 0, 1);
        cyc("R4", 0, 0, 1, 1);
        cyc("R4", 1, 0, 0, 1);
        colls("R4", 18, 1);
        cyc("R4", 0, 0, 1, 1);
        cyc("R4", 1, 0, 0, 1);
        colls("R4", 33, 1);
        cyc("R4", 0, 0, 1, 1);
        // R5: extended abort at 64
        cyc("R5", 1, 0, 0, 1);
        colls("R5", 63, 1);
        cyc("R5", 0, 1, 0, 1);
        cyc("R5", 0, 0, 0, 1);
        colls("R7", 2, 1);
        // R6: mode change mid-frame ignored
        cyc("R6", 1, 0, 0, 0);
        colls("R6", 3, 1);
        cyc("R6", 0, 0, 1, 1);
        // R8: collision with end counted
        cyc("R8", 1, 0, 0, 1);
        cyc("R8", 0, 1, 1, 1);
        cyc("R8", 0, 0, 0, 1);
        // R9: start wins over collision and end, also mid-frame
        cyc("R9", 1, 0, 0, 0);
        colls("R9", 7, 0);
        cyc("R9", 1, 1, 1, 0);
        colls("R9", 2, 0);
        cyc("R9", 0, 0, 1, 0);
        // R6: start clears a held abort flag
        cyc("R6", 1, 0, 0, 0);
        colls("R6", 16, 0);
        cyc("R6", 1, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule